// File: doc/BRIEF.md
# Parallel Pixel Input Deserializer

This block takes pixel data from a parallel input port and turns it into whole pixels on an internal pixel bus. Each assembled pixel appears with a one-cycle valid strobe. Two wide modes deliver one complete pixel per accepted clock: 18-bit RGB666 and 16-bit RGB565. Two byte-wide modes take their data from bits [7:0] only. The first carries RGB565 split into two bytes, in an order chosen by a configuration flag. The second carries YCbCr 4:2:2 as repeating four-byte groups, and each group yields two pixels that share one chroma pair.

An enable input marks the clock cycles that carry data. A frame-start pulse aligns the byte counter to the start of a group. It is also the only point where new mode and byte-order settings are loaded, so a pixel is never built from bytes decoded under two different settings. The block runs entirely in the pixel clock domain. Sync decoding, buffering and colour conversion sit outside it.

Top module: `pixel_deser`

## Requirements
- R1: After reset, `pix_valid` is 0, the byte counter is at the start of a group, and the active setting is the 18-bit wide mode with low-byte-first order (`cfg_mode`=0, `cfg_hi_first`=0). This holds until the first frame start.
- R2: In mode 0 (18-bit wide), each accepted cycle produces a pixel in the next cycle with `pix_c0`=in_data[17:12], `pix_c1`=in_data[11:6], `pix_c2`=in_data[5:0] (zero-extended) and `pix_ycc`=0.
- R3: In mode 1 (16-bit wide), each accepted cycle produces a pixel in the next cycle with `pix_c0`=in_data[15:11], `pix_c1`=in_data[10:5], `pix_c2`=in_data[4:0] and `pix_ycc`=0.
- R4: In mode 2 (byte RGB565), two accepted bytes taken from in_data[7:0] form a 16-bit word W. No pixel follows the first byte. After the second byte the pixel carries `pix_c0`=W[15:11], `pix_c1`=W[10:5], `pix_c2`=W[4:0]. With `cfg_hi_first`=0, the first byte is W[7:0].
- R5: In mode 2 with `cfg_hi_first`=1, the first byte is W[15:8] and the second byte is W[7:0].
- R6: In mode 3 (byte YCbCr), the bytes of a group arrive as Cb, Y0, Cr, Y1. No pixel follows the first two bytes. After the third byte the pixel is (`pix_c0`=Y0, `pix_c1`=Cb, `pix_c2`=Cr). After the fourth it is (Y1, Cb, Cr). Both have `pix_ycc`=1.
- R7: A cycle with `in_en`=0 is ignored. It produces no pixel and does not advance the byte position.
- R8: A cycle with `frame_start`=1 drops any partly assembled pixel and produces no pixel. Its own data is discarded, and the next accepted byte is byte 0 of a group.
- R9: Changes to `cfg_mode` and `cfg_hi_first` have no effect until a cycle with `frame_start`=1 loads them.
- R10: `pix_valid` is high for exactly one cycle per pixel. Between pixels, the component and `pix_ycc` outputs keep the values of the last pixel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Frame/line start: realigns the byte counter and loads the configuration |
| in_en | input | 1 | Marks the cycles that carry input data |
| in_data | input | 18 | Parallel pixel input; byte modes use bits [7:0] |
| cfg_mode | input | 2 | Input mode: 0 wide18, 1 wide16, 2 byte RGB565, 3 byte YCbCr |
| cfg_hi_first | input | 1 | Byte RGB565 order: 1 means the high byte comes first |
| pix_valid | output | 1 | One-cycle strobe for each assembled pixel |
| pix_ycc | output | 1 | 1 when the components are Y/Cb/Cr, 0 when they are R/G/B |
| pix_c0 | output | COMP_W | Red or luma |
| pix_c1 | output | COMP_W | Green or Cb |
| pix_c2 | output | COMP_W | Blue or Cr |

## Verification
Each wide mode is swept over a large set of input words. The wide16 sweep covers all of them, so any swapped or shifted field boundary shows up as a component mismatch. The byte RGB mode runs thousands of words in both byte orders, which separates a correct swap from a missing or reversed one. YCbCr groups use a different arithmetic sequence for each of the four bytes, which exposes any mix-up between Y0 and Y1 or Cb and Cr, and any chroma pair that is not shared. Idle gaps inside a pixel, frame starts that cut a pixel short, and settings changed without a frame start each run against a known clean result, so a phase slip or an early switch of setting changes the pixel that follows.

// File: rtl/pxd_pkg.sv
// Package: shared types and fixed geometry of the pixel input deserializer.
// Assumes: input formats are fixed in width; only the output component
// width is a parameter of the top module.
package pxd_pkg;

    // Input mode as loaded at frame start
    typedef enum logic [1:0] {
        MODE_WIDE18   = 2'd0,
        MODE_WIDE16   = 2'd1,
        MODE_BYTE_RGB = 2'd2,
        MODE_BYTE_YCC = 2'd3
    } in_mode_e;

    localparam int BUS_W  = 18;   // full parallel input width
    localparam int BYTE_W = 8;    // byte-mode lane width
    localparam int PH_W   = 2;    // byte position counter width (up to 4 bytes per group)

    // Index of the last byte of a group for a given mode
    function automatic logic [PH_W-1:0] last_index(in_mode_e m);
        case (m)
            MODE_BYTE_RGB: last_index = PH_W'(1);
            MODE_BYTE_YCC: last_index = PH_W'(3);
            default:       last_index = PH_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/pxd_cfg_shadow.sv
// Module: pxd_cfg_shadow
// Holds the active mode and byte order. The live configuration inputs are
// copied only on a frame-start cycle, so a pixel is never assembled
// across a change of setting.
// Assumes: configuration inputs are static or change freely; only their
// value at a frame-start edge matters.
module pxd_cfg_shadow
    import pxd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic [1:0] mode_in,
    input  logic       hi_first_in,
    output in_mode_e   mode_q,
    output logic       hi_first_q
);

    // Load the shadow configuration at frame start; default after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= MODE_WIDE18;
            hi_first_q <= 1'b0;
        end else if (frame_start) begin
            mode_q     <= in_mode_e'(mode_in);
            hi_first_q <= hi_first_in;
        end
    end

endmodule

// File: rtl/pxd_phase_ctr.sv
// Module: pxd_phase_ctr
// Tracks the position of the current byte inside its group. Advances only
// on accepted cycles, wraps after the mode's last byte, and clears on
// frame start.
// Assumes: wide modes have a one-entry group, so the position stays at 0.
module pxd_phase_ctr
    import pxd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start,
    input  logic            in_en,
    input  in_mode_e        mode,
    output logic [PH_W-1:0] phase,
    output logic            accept,
    output logic            last
);

    // A cycle is taken when enabled and not consumed by a frame start
    always_comb begin
        accept = in_en & ~frame_start;
        last   = (phase == last_index(mode));
    end

    // Byte position: clear on frame start, step or wrap on accepted bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (frame_start) begin
            phase <= '0;
        end else if (accept) begin
            phase <= last ? '0 : phase + PH_W'(1);
        end
    end

endmodule

// File: rtl/pxd_pixel_fmt.sv
// Module: pxd_pixel_fmt
// Keeps the earlier bytes of a group and emits registered pixels with a
// one-cycle valid. Components are zero-extended to CW bits.
// Assumes: CW >= 8; the phase and accept inputs come from pxd_phase_ctr
// running under the same active mode.
module pxd_pixel_fmt
    import pxd_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [PH_W-1:0]  phase,
    input  in_mode_e         mode,
    input  logic             hi_first,
    input  logic [BUS_W-1:0] in_data,
    output logic             pix_valid,
    output logic             pix_ycc,
    output logic [CW-1:0]    pix_c0,
    output logic [CW-1:0]    pix_c1,
    output logic [CW-1:0]    pix_c2
);

    logic [BYTE_W-1:0]   cur_byte;
    logic [BYTE_W-1:0]   hold_first;   // byte 0: RGB first byte or Cb
    logic [BYTE_W-1:0]   hold_y0;      // byte 1 in YCbCr
    logic [BYTE_W-1:0]   hold_cr;      // byte 2 in YCbCr
    logic [2*BYTE_W-1:0] word16;
    logic                emit;
    logic                n_ycc;
    logic [CW-1:0]       n_c0, n_c1, n_c2;

    // Build the byte-mode RGB565 word from the stored and current bytes
    always_comb begin
        cur_byte = in_data[BYTE_W-1:0];
        word16   = hi_first ? {hold_first, cur_byte} : {cur_byte, hold_first};
    end

    // Decide whether this cycle completes a pixel and compute its fields
    always_comb begin
        emit  = 1'b0;
        n_ycc = 1'b0;
        n_c0  = '0;
        n_c1  = '0;
        n_c2  = '0;
        case (mode)
            MODE_WIDE18: begin
                emit = accept;
                n_c0 = CW'(in_data[17:12]);
                n_c1 = CW'(in_data[11:6]);
                n_c2 = CW'(in_data[5:0]);
            end
            MODE_WIDE16: begin
                emit = accept;
                n_c0 = CW'(in_data[15:11]);
                n_c1 = CW'(in_data[10:5]);
                n_c2 = CW'(in_data[4:0]);
            end
            MODE_BYTE_RGB: begin
                emit = accept && (phase == PH_W'(1));
                n_c0 = CW'(word16[15:11]);
                n_c1 = CW'(word16[10:5]);
                n_c2 = CW'(word16[4:0]);
            end
            MODE_BYTE_YCC: begin
                emit  = accept && (phase >= PH_W'(2));
                n_ycc = 1'b1;
                n_c1  = CW'(hold_first);
                if (phase == PH_W'(2)) begin
                    n_c0 = CW'(hold_y0);
                    n_c2 = CW'(cur_byte);
                end else begin
                    n_c0 = CW'(cur_byte);
                    n_c2 = CW'(hold_cr);
                end
            end
        endcase
    end

    // Store the leading bytes of a group as they are accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_first <= '0;
            hold_y0    <= '0;
            hold_cr    <= '0;
        end else if (accept) begin
            if (phase == PH_W'(0)) hold_first <= cur_byte;
            if (phase == PH_W'(1)) hold_y0    <= cur_byte;
            if (phase == PH_W'(2)) hold_cr    <= cur_byte;
        end
    end

    // Register the output pixel; components hold between strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid <= 1'b0;
            pix_ycc   <= 1'b0;
            pix_c0    <= '0;
            pix_c1    <= '0;
            pix_c2    <= '0;
        end else begin
            pix_valid <= emit;
            if (emit) begin
                pix_ycc <= n_ycc;
                pix_c0  <= n_c0;
                pix_c1  <= n_c1;
                pix_c2  <= n_c2;
            end
        end
    end

endmodule

// File: rtl/pixel_deser.sv
// Module: pixel_deser (top)
// Parallel pixel input deserializer: configuration shadow, byte position
// counter and pixel formatter, all in the pixel clock domain.
// Assumes: inputs are synchronous to clk; COMP_W >= 8.
module pixel_deser
    import pxd_pkg::*;
#(
    parameter int COMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              in_en,
    input  logic [17:0]       in_data,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_hi_first,
    output logic              pix_valid,
    output logic              pix_ycc,
    output logic [COMP_W-1:0] pix_c0,
    output logic [COMP_W-1:0] pix_c1,
    output logic [COMP_W-1:0] pix_c2
);

    in_mode_e        act_mode;
    logic            act_hi_first;
    logic [PH_W-1:0] phase;
    logic            accept;
    logic            grp_last;

    pxd_cfg_shadow u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .mode_in     (cfg_mode),
        .hi_first_in (cfg_hi_first),
        .mode_q      (act_mode),
        .hi_first_q  (act_hi_first)
    );

    pxd_phase_ctr u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .in_en       (in_en),
        .mode        (act_mode),
        .phase       (phase),
        .accept      (accept),
        .last        (grp_last)
    );

    pxd_pixel_fmt #(.CW(COMP_W)) u_fmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .phase     (phase),
        .mode      (act_mode),
        .hi_first  (act_hi_first),
        .in_data   (in_data),
        .pix_valid (pix_valid),
        .pix_ycc   (pix_ycc),
        .pix_c0    (pix_c0),
        .pix_c1    (pix_c1),
        .pix_c2    (pix_c2)
    );

    logic unused_last;
    assign unused_last = grp_last;

endmodule

// File: rtl/pxd_checker.sv
// Module: pxd_checker
// Protocol and mapping properties of pixel_deser, attached by bind.
// Assumes: sees the active configuration and byte position of the top.
module pxd_checker
    import pxd_pkg::*;
#(
    parameter int CW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frame_start,
    input logic            in_en,
    input logic [17:0]     in_data,
    input logic            pix_valid,
    input logic            pix_ycc,
    input logic [CW-1:0]   pix_c0,
    input logic [CW-1:0]   pix_c1,
    input logic [CW-1:0]   pix_c2,
    input in_mode_e        act_mode,
    input logic            act_hi_first,
    input logic [PH_W-1:0] phase
);

    // R1: first cycle out of reset is idle at group start
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!pix_valid && phase == '0));

    // R2: wide18 field mapping, one-cycle latency
    p_wide18_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == MODE_WIDE18 && in_en && !frame_start) |=>
        (pix_valid && pix_c0 == CW'($past(in_data[17:12])) &&
         pix_c1 == CW'($past(in_data[11:6])) && pix_c2 == CW'($past(in_data[5:0]))));

    // R3: wide16 field mapping, one-cycle latency
    p_wide16_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == MODE_WIDE16 && in_en && !frame_start) |=>
        (pix_valid && pix_c0 == CW'($past(in_data[15:11])) &&
         pix_c1 == CW'($past(in_data[10:5])) && pix_c2 == CW'($past(in_data[4:0]))));

    // R4: byte RGB pixels need two bytes, so strobes never touch
    p_byte_rgb_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == MODE_BYTE_RGB && pix_valid) |=> !pix_valid);

    // R6: third and fourth bytes of a YCbCr group each yield a pixel
    p_ycc_emit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == MODE_BYTE_YCC && in_en && !frame_start && phase >= PH_W'(2)) |=> pix_valid);

    // R6: the format flag follows the mode that produced the pixel
    p_ycc_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pix_ycc == (act_mode == MODE_BYTE_YCC)));

    // R7: idle cycles hold the byte position and give no pixel
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_en && !frame_start) |=> ($stable(phase) && !pix_valid));

    // R8: frame start realigns to byte 0 and gives no pixel
    p_frame_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (phase == '0 && !pix_valid));

    // R9: the active configuration changes only at frame start
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(act_mode) && $stable(act_hi_first)));

    // R10: components hold between strobes
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> ($stable(pix_c0) && $stable(pix_c1) && $stable(pix_c2) && $stable(pix_ycc)));

endmodule

bind pixel_deser pxd_checker #(.CW(COMP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .in_en        (in_en),
    .in_data      (in_data),
    .pix_valid    (pix_valid),
    .pix_ycc      (pix_ycc),
    .pix_c0       (pix_c0),
    .pix_c1       (pix_c1),
    .pix_c2       (pix_c2),
    .act_mode     (act_mode),
    .act_hi_first (act_hi_first),
    .phase        (phase)
);

// File: tb/sim_pixel_deser.sv
module sim_pixel_deser;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_start;
    logic        in_en;
    logic [17:0] in_data;
    logic [1:0]  cfg_mode;
    logic        cfg_hi_first;
    logic        pix_valid;
    logic        pix_ycc;
    logic [7:0]  pix_c0, pix_c1, pix_c2;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    pixel_deser #(.COMP_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_en(in_en),
        .in_data(in_data), .cfg_mode(cfg_mode), .cfg_hi_first(cfg_hi_first),
        .pix_valid(pix_valid), .pix_ycc(pix_ycc),
        .pix_c0(pix_c0), .pix_c1(pix_c1), .pix_c2(pix_c2)
    );

    function automatic logic [31:0] px(logic v, logic y, logic [7:0] a, logic [7:0] b, logic [7:0] c);
        return {6'b0, v, y, a, b, c};
    endfunction

    function automatic logic [31:0] actual();
        return {6'b0, pix_valid, pix_ycc, pix_c0, pix_c1, pix_c2};
    endfunction

    function automatic logic [31:0] rgb565(logic [15:0] w);
        return px(1'b1, 1'b0, {3'b0, w[15:11]}, {2'b0, w[10:5]}, {3'b0, w[4:0]});
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge: drive, let one edge pass, return at the next negedge
    task automatic step(logic fs, logic en, logic [17:0] d);
        frame_start = fs;
        in_en       = en;
        in_data     = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_cfg(logic [1:0] m, logic hf);
        cfg_mode     = m;
        cfg_hi_first = hf;
        step(1'b1, 1'b1, 18'h3FFFF);
        check("R8", {31'b0, pix_valid}, 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] last_px;
        rst_n = 1'b0; frame_start = 1'b0; in_en = 1'b0; in_data = '0;
        cfg_mode = 2'd3; cfg_hi_first = 1'b1;
        @(negedge clk);
        step(1'b0, 1'b1, 18'h12345);
        step(1'b0, 1'b1, 18'h12345);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 18'h0);
        check("R1", actual(), px(0, 0, 0, 0, 0));

        // R1/R9: default mode is wide18 even though cfg_mode reads 3
        step(1'b0, 1'b1, 18'h2B5A3);
        check("R1", actual(), px(1, 0, 8'h2B, 8'h16, 8'h23));

        // R2: wide18 sweep
        for (int i = 0; i < 4096; i++) begin
            logic [17:0] d;
            d = 18'((i * 6151) ^ (i << 6) ^ (i * i * 3));
            step(1'b0, 1'b1, d);
            check("R2", actual(), px(1, 0, {2'b0, d[17:12]}, {2'b0, d[11:6]}, {2'b0, d[5:0]}));
        end

        // R10: idle cycle drops the strobe and holds the fields
        last_px = actual();
        step(1'b0, 1'b0, 18'h15555);
        check("R10", actual(), {last_px[31:26], 1'b0, last_px[24:0]});

        // R3: wide16 full sweep, upper bits set to junk
        load_cfg(2'd1, 1'b0);
        for (int i = 0; i < 65536; i++) begin
            logic [15:0] w;
            w = 16'(i);
            step(1'b0, 1'b1, {2'b11, w});
            check("R3", actual(), rgb565(w));
        end

        // R4: byte RGB, low byte first
        load_cfg(2'd2, 1'b0);
        for (int i = 0; i < 4096; i++) begin
            logic [15:0] w;
            w = 16'(i * 40503 + 7);
            step(1'b0, 1'b1, {10'h2AA, w[7:0]});
            check("R4", {31'b0, pix_valid}, 32'd0);
            step(1'b0, 1'b1, {10'h155, w[15:8]});
            check("R4", actual(), rgb565(w));
        end

        // R5: byte RGB, high byte first
        load_cfg(2'd2, 1'b1);
        for (int i = 0; i < 4096; i++) begin
            logic [15:0] w;
            w = 16'(i * 25173 + 13849);
            step(1'b0, 1'b1, {10'h0, w[15:8]});
            check("R5", {31'b0, pix_valid}, 32'd0);
            step(1'b0, 1'b1, {10'h3FF, w[7:0]});
            check("R5", actual(), rgb565(w));
        end

        // R7: idle gap inside a pixel
        step(1'b0, 1'b1, 18'h000C3);
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 1'b0, 18'h000FF);
            check("R7", {31'b0, pix_valid}, 32'd0);
        end
        step(1'b0, 1'b1, 18'h0005A);
        check("R7", actual(), rgb565(16'hC35A));

        // R8: frame start cuts a half pixel; its own byte is dropped
        step(1'b0, 1'b1, 18'h00077);
        step(1'b1, 1'b1, 18'h00088);
        check("R8", {31'b0, pix_valid}, 32'd0);
        step(1'b0, 1'b1, 18'h000A5);
        check("R8", {31'b0, pix_valid}, 32'd0);
        step(1'b0, 1'b1, 18'h0003C);
        check("R8", actual(), rgb565(16'hA53C));

        // R6: YCbCr groups
        load_cfg(2'd3, 1'b0);
        for (int g = 0; g < 1024; g++) begin
            logic [7:0] cb, y0, cr, y1;
            cb = 8'(g);
            y0 = 8'(g * 7 + 3);
            cr = 8'(g * 13 + 5);
            y1 = 8'(g * 29 + 1);
            step(1'b0, 1'b1, {10'h0, cb});
            check("R6", {31'b0, pix_valid}, 32'd0);
            step(1'b0, 1'b1, {10'h0, y0});
            check("R6", {31'b0, pix_valid}, 32'd0);
            step(1'b0, 1'b1, {10'h0, cr});
            check("R6", actual(), px(1, 1, y0, cb, cr));
            step(1'b0, 1'b1, {10'h0, y1});
            check("R6", actual(), px(1, 1, y1, cb, cr));
        end

        // R9: new setting without frame start is not used
        cfg_mode = 2'd0;
        step(1'b0, 1'b1, 18'h00011);
        step(1'b0, 1'b1, 18'h00022);
        check("R9", {31'b0, pix_valid}, 32'd0);
        step(1'b0, 1'b1, 18'h00033);
        check("R9", actual(), px(1, 1, 8'h22, 8'h11, 8'h33));
        step(1'b0, 1'b1, 18'h00044);
        check("R9", actual(), px(1, 1, 8'h44, 8'h11, 8'h33));

        // R8: realign in YCbCr after two bytes
        cfg_mode = 2'd3;
        step(1'b0, 1'b1, 18'h00091);
        step(1'b0, 1'b1, 18'h00092);
        step(1'b1, 1'b0, 18'h0);
        step(1'b0, 1'b1, 18'h000B0);
        step(1'b0, 1'b1, 18'h000B1);
        check("R8", {31'b0, pix_valid}, 32'd0);
        step(1'b0, 1'b1, 18'h000B2);
        check("R8", actual(), px(1, 1, 8'hB1, 8'hB0, 8'hB2));

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule